// File: doc/BRIEF.md
# Serial Word Transmitter with Loopback

This block takes a pre-encoded 10-bit word once per word period and sends it out one bit per cycle of a fast bit clock. The fast clock runs at ten times the word rate, and a single-cycle load strobe marks each rising edge of the word-rate reference clock. Bit 0 goes out first and bit 9 goes out last. A word captured while another is still being sent is queued in a capture register. The shifter picks it up in the cycle right after the current word's last bit, so a strobe every ten cycles gives a continuous stream with no gap.

A loopback control chooses where the serial stream goes. With loopback low, the stream drives the external serial output, and the external serial input is passed through to the receive-side serial output. With loopback high, the stream is sent to the receive-side output, the external input is ignored, and the external output is held at a fixed static level. A synchronous reset clears the capture and shift registers and returns the line to the static level.

The shifter is a two-state machine. `SH_IDLE` holds the line at the static level. `SH_SEND` shifts out the word. The transitions are:
- `LOAD_FIRST`: `SH_IDLE` to `SH_SEND` when a word is pending.
- `RELOAD`: `SH_SEND` to `SH_SEND` on the last bit when another word is pending.
- `DRAIN`: `SH_SEND` to `SH_IDLE` on the last bit when no word is pending.

Top module: `ser_word_tx`

## Requirements
- R1: A word presented with `word_stb` high in cycle n is captured at the end of cycle n, and its first bit appears on the stream in cycle n+2 if the shifter is idle.
- R2: Word bit j, with bit 0 the least significant bit of `word_in`, appears on the stream in the j-th cycle after the word's first bit, for j = 0..9.
- R3: With strobes exactly 10 cycles apart, bit 0 of each word immediately follows bit 9 of the previous word, with no idle cycle between them.
- R4: When no word is pending after bit 9, the stream falls to the static level `STATIC_LVL` (default 0) and stays there. Strobes spaced P >= 10 cycles apart still start each word 2 cycles after its strobe.
- R5: While `loop_en` is 1, `ser_tx_out` equals `STATIC_LVL` in every cycle.
- R6: While `loop_en` is 0, `ser_tx_out` carries the stream and `rx_ser_out` equals `ext_rx_in` in the same cycle.
- R7: While `loop_en` is 1, `rx_ser_out` carries the stream in the same cycle, whatever `ext_rx_in` does.
- R8: With `rst` high in cycle n, the line is at `STATIC_LVL` from cycle n+1. Any partly sent word and any pending word are discarded.
- R9: If several strobes arrive before the shifter reloads, only the most recently captured word is sent, and the earlier pending word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | WORD_W | Pre-encoded word, bit 0 sent first |
| word_stb | input | 1 | Word-load strobe, one cycle per reference edge |
| loop_en | input | 1 | Loopback enable |
| ext_rx_in | input | 1 | External serial input toward the receiver |
| ser_tx_out | output | 1 | External serial output |
| rx_ser_out | output | 1 | Serial stream toward the local receiver |

## Verification
Bit j of a word strobed in cycle n is due in cycle n+2+j. A reset asserted in cycle n takes effect in cycle n+1. The loopback routing and the pass-through of the external input are combinational, so they act in the same cycle. The bench drives every input on the falling edge and checks both outputs 1 ns later, against expected values built from these offsets for each cycle. In addition, a reference deserializer gathers the bits seen on the active output and compares each recovered word with the word sent, including a sweep of all 1024 word values through loopback.

// File: rtl/ser_word_tx_pkg.sv
package ser_word_tx_pkg;
    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_SEND = 1'b1
    } sh_state_e;
endpackage

// File: rtl/tx_word_capture.sv
module tx_word_capture #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] word_in,
    input  logic              load_take,
    output logic [WORD_W-1:0] cap_word,
    output logic              cap_pend
);
    // A new strobe always wins over the shifter taking the old word.
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_word <= '0;
            cap_pend <= 1'b0;
        end else if (word_stb) begin
            cap_word <= word_in;
            cap_pend <= 1'b1;
        end else if (load_take) begin
            cap_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_word_shifter.sv
module tx_word_shifter
    import ser_word_tx_pkg::*;
#(
    parameter int   WORD_W     = 10,
    parameter logic STATIC_LVL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] cap_word,
    input  logic              cap_pend,
    output logic              load_take,
    output logic              busy,
    output logic              stream
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    sh_state_e         state, nxt;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              at_last;

    assign at_last = (bit_cnt == LAST_BIT);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= SH_IDLE;
        else     state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (load_take) begin
            shreg   <= cap_word;
            bit_cnt <= '0;
        end else if (state == SH_SEND) begin
            shreg   <= shreg >> 1;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // transitions: LOAD_FIRST, RELOAD, DRAIN
    always_comb begin
        nxt       = state;
        load_take = 1'b0;
        unique case (state)
            SH_IDLE: begin
                if (cap_pend) begin
                    load_take = 1'b1;
                    nxt       = SH_SEND;
                end
            end
            SH_SEND: begin
                if (at_last) begin
                    if (cap_pend) load_take = 1'b1;
                    else          nxt       = SH_IDLE;
                end
            end
            default: nxt = SH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = (state == SH_SEND);
        stream = busy ? shreg[0] : STATIC_LVL;
    end
endmodule

// File: rtl/tx_loop_mux.sv
module tx_loop_mux #(
    parameter logic STATIC_LVL = 1'b0
) (
    input  logic loop_en,
    input  logic stream,
    input  logic ext_rx_in,
    output logic ser_tx_out,
    output logic rx_ser_out
);
    always_comb begin
        if (loop_en) begin
            ser_tx_out = STATIC_LVL;
            rx_ser_out = stream;
        end else begin
            ser_tx_out = stream;
            rx_ser_out = ext_rx_in;
        end
    end
endmodule

// File: rtl/ser_word_tx.sv
module ser_word_tx #(
    parameter int   WORD_W     = 10,
    parameter logic STATIC_LVL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_stb,
    input  logic              loop_en,
    input  logic              ext_rx_in,
    output logic              ser_tx_out,
    output logic              rx_ser_out
);
    logic [WORD_W-1:0] cap_word;
    logic              cap_pend;
    logic              load_take;
    logic              shift_busy;
    logic              tx_stream;

    tx_word_capture #(.WORD_W(WORD_W)) u_cap (
        .clk(clk), .rst(rst), .word_stb(word_stb), .word_in(word_in),
        .load_take(load_take), .cap_word(cap_word), .cap_pend(cap_pend)
    );

    tx_word_shifter #(.WORD_W(WORD_W), .STATIC_LVL(STATIC_LVL)) u_shift (
        .clk(clk), .rst(rst), .cap_word(cap_word), .cap_pend(cap_pend),
        .load_take(load_take), .busy(shift_busy), .stream(tx_stream)
    );

    tx_loop_mux #(.STATIC_LVL(STATIC_LVL)) u_mux (
        .loop_en(loop_en), .stream(tx_stream), .ext_rx_in(ext_rx_in),
        .ser_tx_out(ser_tx_out), .rx_ser_out(rx_ser_out)
    );
endmodule

// File: rtl/ser_word_tx_chk.sv
module ser_word_tx_chk #(
    parameter logic STATIC_LVL = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic word_stb,
    input logic loop_en,
    input logic ext_rx_in,
    input logic ser_tx_out,
    input logic rx_ser_out,
    input logic pend,
    input logic busy,
    input logic stream
);
    // R1
    capture_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(word_stb)) |-> pend);

    // R4
    idle_static_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (stream == STATIC_LVL));

    // R5
    loop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (ser_tx_out == STATIC_LVL));

    // R6
    ext_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !loop_en |-> (rx_ser_out == ext_rx_in));

    // R7
    loop_route_chk: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (rx_ser_out == stream));

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !loop_en) |-> (ser_tx_out == STATIC_LVL));
endmodule

bind ser_word_tx ser_word_tx_chk #(.STATIC_LVL(STATIC_LVL)) u_chk (
    .clk(clk), .rst(rst), .word_stb(word_stb), .loop_en(loop_en),
    .ext_rx_in(ext_rx_in), .ser_tx_out(ser_tx_out), .rx_ser_out(rx_ser_out),
    .pend(cap_pend), .busy(shift_busy), .stream(tx_stream)
);

// File: tb/tb_ser_word_tx.sv
`timescale 1ns/1ps
module tb_ser_word_tx;
    localparam int MAXC = 10400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] word_in = '0;
    logic       word_stb = 1'b0;
    logic       loop_en = 1'b0;
    logic       ext_rx_in = 1'b0;
    logic       ser_tx_out, rx_ser_out;

    always #2 clk = ~clk;

    ser_word_tx dut (
        .clk(clk), .rst(rst), .word_in(word_in), .word_stb(word_stb),
        .loop_en(loop_en), .ext_rx_in(ext_rx_in),
        .ser_tx_out(ser_tx_out), .rx_ser_out(rx_ser_out)
    );

    logic       a_rst [MAXC];
    logic       a_stb [MAXC];
    logic [9:0] a_word[MAXC];
    logic       a_loop[MAXC];
    logic       a_ext [MAXC];
    logic       a_exp [MAXC];
    logic       a_wend[MAXC];
    logic [9:0] a_wexp[MAXC];

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;

    task automatic clear_sched();
        for (int c = 0; c < MAXC; c++) begin
            a_rst[c]  = (c == 0);
            a_stb[c]  = 1'b0;
            a_word[c] = '0;
            a_loop[c] = 1'b0;
            a_ext[c]  = ((c >> 1) & 1) ^ ((c % 5) == 0) ^ ((c >> 3) & 1);
            a_exp[c]  = 1'b0;
            a_wend[c] = 1'b0;
            a_wexp[c] = '0;
        end
    endtask

    task automatic put_word(input int c, input logic [9:0] w);
        a_stb[c]  = 1'b1;
        a_word[c] = w;
    endtask

    task automatic put_bits(input int c0, input logic [9:0] w, input bit track);
        for (int j = 0; j < 10; j++) a_exp[c0 + j] = w[j];
        if (track) begin
            a_wend[c0 + 9] = 1'b1;
            a_wexp[c0 + 9] = w;
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string req,
                             input string tname, input int c);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s [%s] cycle %0d: got %0b expected %0b", req, tname, c, act, exp);
        end
    endtask

    task automatic run_sched(input int len, input string tname);
        logic [9:0] des;
        logic       vis;
        des = '0;
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            rst       = a_rst[c];
            word_stb  = a_stb[c];
            word_in   = a_word[c];
            loop_en   = a_loop[c];
            ext_rx_in = a_ext[c];
            #1;
            if (a_loop[c]) begin
                check_bit(ser_tx_out, 1'b0, "R5", tname, c);
                check_bit(rx_ser_out, a_exp[c], "R7", tname, c);
                vis = rx_ser_out;
            end else begin
                check_bit(ser_tx_out, a_exp[c], "R6 R2", tname, c);
                check_bit(rx_ser_out, a_ext[c], "R6", tname, c);
                vis = ser_tx_out;
            end
            des = {vis, des[9:1]};
            if (a_wend[c]) begin
                nchk++;
                if (des !== a_wexp[c]) begin
                    nfail++;
                    $display("FAIL R2 [%s] word ending cycle %0d: got %03h expected %03h",
                             tname, c, des, a_wexp[c]);
                end
            end
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);

        // R8: state right after reset
        clear_sched();
        run_sched(12, "R8 reset state");

        // R1 R2 R3: gapless burst on the external line
        clear_sched();
        for (int i = 0; i < 64; i++) begin
            put_word(3 + 10 * i, 10'((i * 97 + 13) & 1023));
            put_bits(5 + 10 * i, 10'((i * 97 + 13) & 1023), 1'b1);
        end
        run_sched(3 + 640 + 15, "R1 R2 R3 external burst");

        // R3 R7: every word value through loopback
        clear_sched();
        for (int c = 0; c < 3 + 10240 + 15; c++) a_loop[c] = 1'b1;
        for (int i = 0; i < 1024; i++) begin
            put_word(3 + 10 * i, 10'(i));
            put_bits(5 + 10 * i, 10'(i), 1'b1);
        end
        run_sched(3 + 10240 + 15, "R3 R7 exhaustive loopback");

        // R4: spaced strobes leave idle gaps at the static level
        clear_sched();
        n = 3;
        for (int i = 0; i < 10; i++) begin
            put_word(n, 10'((i * 211 + 50) & 1023));
            put_bits(n + 2, 10'((i * 211 + 50) & 1023), 1'b1);
            n += 10 + (i % 5);
        end
        run_sched(n + 15, "R4 spaced words");

        // R9: C overwrites pending B; A then C are sent
        clear_sched();
        put_word(3, 10'h2B5);
        put_word(7, 10'h0F0);
        put_word(10, 10'h3C3);
        put_bits(5, 10'h2B5, 1'b1);
        put_bits(15, 10'h3C3, 1'b1);
        run_sched(40, "R9 overwrite");

        // R8: reset mid-word drops the rest and the pending word
        clear_sched();
        put_word(3, 10'h1AB);
        put_word(8, 10'h3FF);
        a_rst[9] = 1'b1;
        for (int j = 0; j < 5; j++) a_exp[5 + j] = 10'h1AB >> j;
        run_sched(30, "R8 mid-word reset");

        // R5 R6 R7: loopback toggled during a burst
        clear_sched();
        for (int c = 0; c < 78; c++) a_loop[c] = ((c / 7) & 1);
        for (int i = 0; i < 6; i++) begin
            put_word(3 + 10 * i, 10'((i * 331 + 7) & 1023));
            put_bits(5 + 10 * i, 10'((i * 331 + 7) & 1023), 1'b0);
        end
        run_sched(78, "R5 R6 R7 loop toggle");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nfail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule